// File: doc/BRIEF.md
# Sleep and Wake-Up Sequencer

This block sequences power-down and wake-up for a small 8-bit microcontroller core. The core gives it a one-cycle strobe when a sleep instruction executes. The block also takes a watchdog timeout with its enable, a device reset request, a vector of interrupt flags with their enables, and the global interrupt enable. From these it keeps the power-down and timeout status flags, pulses the watchdog clear and stops the oscillator.

While asleep it waits for a wake event: a reset request, an enabled watchdog timeout, or any interrupt flag whose own enable is set. The global enable plays no part in waking. A wake restarts the oscillator. In crystal mode it then counts a start-up delay before it strobes `resume` to the core. After an interrupt wake with global interrupts enabled, it lets the next instruction run, inserts one dummy cycle and then raises a one-cycle vector request. A flag that is already pending when the sleep strobe arrives turns the sleep into a no-op. A flag that rises the cycle after the strobe lets the sleep complete and wakes the block at once.

Top module: `slpwake_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, the block is awake: `pd_flag`=1, `to_flag`=1, `osc_en`=1, and `asleep`, `ost_busy`, `resume`, `vector_req`, `wdt_clear` and `reset_out` are all 0.
- R2: A sleep strobe while awake, with no enabled flag pending (pending means `int_flags & int_ens` is non-zero), has these effects from the next cycle: `asleep`=1, `pd_flag`=0, `to_flag`=1, `osc_en`=0. `wdt_clear` is high for exactly that one cycle.
- R3: A sleep strobe while an enabled flag is pending is a no-op. The block stays awake, `wdt_clear` stays 0, and `pd_flag` and `to_flag` keep their values.
- R4: A flag whose enable bit is 0 neither blocks a sleep nor ends one.
- R5: While asleep, a pending enabled flag wakes the block on the next cycle (`asleep`=0, `osc_en`=1) whatever the value of `gie`. This includes a flag that first rises in the cycle right after the sleep strobe; that sleep has already completed with all the effects of R2.
- R6: While asleep, a watchdog timeout wakes the block only if `wdt_en`=1. Such a wake clears `to_flag` to 0, and execution resumes in-line without a vector request.
- R7: A `dev_reset_req` in any state returns the block to the awake state with `osc_en`=1, and `reset_out` pulses high on the next cycle. The status flags keep their values.
- R8: A watchdog timeout with `wdt_en`=1 while awake clears `to_flag`, pulses `reset_out` on the next cycle and leaves `pd_flag` unchanged.
- R9: With `osc_rc_mode`=0, `ost_busy` is high for exactly OST_CYCLES cycles after a wake, and `resume` follows in the next cycle. With `osc_rc_mode`=1, `resume` is high in the cycle right after the wake.
- R10: `resume` is a single-cycle strobe. After a watchdog wake, or an interrupt wake with `gie`=0 at the wake, the block is awake again in the next cycle and `vector_req` stays 0.
- R11: After an interrupt wake with `gie`=1 at the wake, the cycle after `resume` runs the next instruction and the following cycle is a dummy. `vector_req` is then high for exactly one cycle, three cycles after `resume`.
- R12: While asleep, a reset request takes priority over a watchdog timeout, and a watchdog timeout takes priority over an interrupt. In each case the lower-priority event has no effect on the flags or on the vector path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sleep_exec | input | 1 | One-cycle strobe: a sleep instruction executes |
| wdt_timeout | input | 1 | Watchdog counter expired |
| wdt_en | input | 1 | Watchdog enabled |
| dev_reset_req | input | 1 | Device reset request (any source other than power-on) |
| int_flags | input | N_SRC | Interrupt flags, one per source |
| int_ens | input | N_SRC | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| osc_rc_mode | input | 1 | 1: RC oscillator, no start-up delay; 0: crystal mode with delay |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Timeout status flag |
| wdt_clear | output | 1 | One-cycle watchdog and postscaler clear |
| osc_en | output | 1 | Oscillator driver enable |
| asleep | output | 1 | Block is in the sleep state |
| ost_busy | output | 1 | Oscillator start-up delay running |
| resume | output | 1 | One-cycle strobe: core restarts fetch |
| vector_req | output | 1 | One-cycle request to fetch the interrupt vector |
| reset_out | output | 1 | One-cycle device reset pulse |

## Verification
The hardest case to reach is the race between an interrupt flag and the sleep strobe. A flag that is set in the same cycle as the strobe must cancel the sleep. A flag that rises one cycle later must let the sleep complete and still wake the block at once. The bench drives inputs on the falling edge, so it can place a flag exactly in the strobe cycle and, separately, exactly one cycle after it. It also drives a reset request, a watchdog timeout and an interrupt in the same sleeping cycle to exercise the priority order.

// File: rtl/slpwake_pkg.sv
// Shared types for the sleep/wake sequencer.
// Assumes: one state encoding is shared by the FSM and the top-level decode.
package slpwake_pkg;
    typedef enum logic [2:0] {
        ST_AWAKE  = 3'd0,
        ST_SLEEP  = 3'd1,
        ST_WARM   = 3'd2,
        ST_RESUME = 3'd3,
        ST_NEXTI  = 3'd4,
        ST_DUMMY  = 3'd5,
        ST_VECTOR = 3'd6
    } state_e;
endpackage

// File: rtl/slpwake_irq_eval.sv
// Per-source wake qualification: a source counts only when its own enable
// is set. Assumes flags and enables are already synchronous to clk.
module slpwake_irq_eval #(
    parameter int N_SRC = 3
) (
    input  logic [N_SRC-1:0] int_flags,
    input  logic [N_SRC-1:0] int_ens,
    output logic             irq_pend
);
    logic [N_SRC-1:0] hit;

    // One qualifying gate per interrupt source.
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = int_flags[i] & int_ens[i];
    end

    // Any qualified source makes the wake request pending.
    assign irq_pend = |hit;
endmodule

// File: rtl/slpwake_ost_cnt.sv
// Oscillator start-up down-counter. A load sets it to OST_CYCLES-1 and it
// counts down to zero and then holds. Assumes OST_CYCLES >= 2.
module slpwake_ost_cnt #(
    parameter int OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CNT_W = $clog2(OST_CYCLES);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(OST_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Load on a wake, otherwise count down until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= LOAD_VAL;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/slpwake_fsm.sv
// Sequencer core: sleep entry and the sleep no-op, wake arbitration, the
// start-up wait, the resume strobe and the vector path. It also holds the
// power-down and timeout status flags.
// Assumes sleep_exec is a single-cycle strobe from the core decoder.
module slpwake_fsm
    import slpwake_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sleep_exec,
    input  logic   wdt_timeout,
    input  logic   wdt_en,
    input  logic   reset_req,
    input  logic   irq_pend,
    input  logic   gie,
    input  logic   osc_rc_mode,
    input  logic   ost_done,
    output logic   ost_load,
    output state_e state,
    output logic   pd_flag,
    output logic   to_flag,
    output logic   wdt_clear,
    output logic   reset_out
);
    state_e nxt;
    logic   wdt_hit;
    logic   wake_go;
    logic   wake_irq;
    logic   take_vec;

    assign wdt_hit  = wdt_timeout & wdt_en;
    assign ost_load = wake_go & ~osc_rc_mode;

    // Next state and wake arbitration (reset > watchdog > interrupt).
    always_comb begin
        nxt      = state;
        wake_go  = 1'b0;
        wake_irq = 1'b0;
        case (state)
            ST_AWAKE:  if (!wdt_hit && sleep_exec && !irq_pend) nxt = ST_SLEEP;
            ST_SLEEP:  if (wdt_hit || irq_pend) begin
                           wake_go  = ~reset_req;
                           wake_irq = ~wdt_hit;
                           nxt      = osc_rc_mode ? ST_RESUME : ST_WARM;
                       end
            ST_WARM:   if (ost_done) nxt = ST_RESUME;
            ST_RESUME: nxt = take_vec ? ST_NEXTI : ST_AWAKE;
            ST_NEXTI:  nxt = ST_DUMMY;
            ST_DUMMY:  nxt = ST_VECTOR;
            ST_VECTOR: nxt = ST_AWAKE;
            default:   nxt = ST_AWAKE;
        endcase
        if (reset_req)
            nxt = ST_AWAKE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_AWAKE;
        else
            state <= nxt;
    end

    // Status flags, one-cycle pulses and the vector decision taken at wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_flag   <= 1'b1;
            to_flag   <= 1'b1;
            wdt_clear <= 1'b0;
            reset_out <= 1'b0;
            take_vec  <= 1'b0;
        end else begin
            wdt_clear <= 1'b0;
            reset_out <= reset_req;
            if (!reset_req) begin
                if (state == ST_AWAKE) begin
                    if (wdt_hit) begin
                        to_flag   <= 1'b0;
                        reset_out <= 1'b1;
                    end else if (sleep_exec && !irq_pend) begin
                        pd_flag   <= 1'b0;
                        to_flag   <= 1'b1;
                        wdt_clear <= 1'b1;
                    end
                end else if (wake_go) begin
                    take_vec <= wake_irq & gie;
                    if (wdt_hit)
                        to_flag <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/slpwake_ctrl.sv
// Top of the sleep/wake sequencer. It joins source qualification, the
// start-up counter and the FSM, and decodes the state into core-facing
// strobes. Assumes all inputs are synchronous to clk.
module slpwake_ctrl #(
    parameter int N_SRC      = 3,
    parameter int OST_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_exec,
    input  logic             wdt_timeout,
    input  logic             wdt_en,
    input  logic             dev_reset_req,
    input  logic [N_SRC-1:0] int_flags,
    input  logic [N_SRC-1:0] int_ens,
    input  logic             gie,
    input  logic             osc_rc_mode,
    output logic             pd_flag,
    output logic             to_flag,
    output logic             wdt_clear,
    output logic             osc_en,
    output logic             asleep,
    output logic             ost_busy,
    output logic             resume,
    output logic             vector_req,
    output logic             reset_out
);
    import slpwake_pkg::*;

    logic   irq_pend;
    logic   ost_load;
    logic   ost_done;
    logic   in_awake;
    state_e state;

    slpwake_irq_eval #(.N_SRC(N_SRC)) u_irq (
        .int_flags (int_flags),
        .int_ens   (int_ens),
        .irq_pend  (irq_pend)
    );

    slpwake_ost_cnt #(.OST_CYCLES(OST_CYCLES)) u_ost (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ost_load),
        .done  (ost_done)
    );

    slpwake_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_exec  (sleep_exec),
        .wdt_timeout (wdt_timeout),
        .wdt_en      (wdt_en),
        .reset_req   (dev_reset_req),
        .irq_pend    (irq_pend),
        .gie         (gie),
        .osc_rc_mode (osc_rc_mode),
        .ost_done    (ost_done),
        .ost_load    (ost_load),
        .state       (state),
        .pd_flag     (pd_flag),
        .to_flag     (to_flag),
        .wdt_clear   (wdt_clear),
        .reset_out   (reset_out)
    );

    // Core-facing decode of the sequencer state.
    assign in_awake   = (state == ST_AWAKE);
    assign asleep     = (state == ST_SLEEP);
    assign osc_en     = (state != ST_SLEEP);
    assign ost_busy   = (state == ST_WARM);
    assign resume     = (state == ST_RESUME);
    assign vector_req = (state == ST_VECTOR);
endmodule

// File: rtl/slpwake_ctrl_chk.sv
// Property checker for slpwake_ctrl, bound to every instance of it.
// Assumes it sees the top-level ports and the internal pending and awake
// signals.
module slpwake_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_exec,
    input logic wdt_timeout,
    input logic wdt_en,
    input logic dev_reset_req,
    input logic irq_pend,
    input logic in_awake,
    input logic pd_flag,
    input logic to_flag,
    input logic wdt_clear,
    input logic osc_en,
    input logic asleep,
    input logic resume,
    input logic vector_req,
    input logic reset_out
);
    // R2: a sleep with nothing pending completes with all its side effects.
    p_sleep_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_awake && sleep_exec && !irq_pend && !dev_reset_req && !(wdt_timeout && wdt_en)
        |=> asleep && !pd_flag && to_flag && wdt_clear && !osc_en);

    // R2: the watchdog clear is a single-cycle pulse.
    p_wclr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |=> !wdt_clear);

    // R3: a sleep with a pending enabled flag is a no-op.
    p_sleep_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_awake && sleep_exec && irq_pend && !dev_reset_req && !(wdt_timeout && wdt_en)
        |=> !asleep && !wdt_clear && $stable(pd_flag) && $stable(to_flag));

    // R5: a pending enabled flag wakes the block on the next cycle.
    p_wake_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        asleep && irq_pend && !dev_reset_req |=> !asleep && osc_en);

    // R6: a disabled watchdog never wakes the block.
    p_wdt_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        asleep && !wdt_en && !irq_pend && !dev_reset_req |=> asleep);

    // R7: a reset request always yields a reset pulse and the awake state.
    p_reset_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset_req |=> reset_out && !asleep && osc_en);

    // R11: the vector request lasts exactly one cycle.
    p_vec_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vector_req |=> !vector_req);

    // R11: the vector request comes three cycles after the resume strobe.
    p_vec_after_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vector_req |-> $past(resume, 3));
endmodule

bind slpwake_ctrl slpwake_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_exec    (sleep_exec),
    .wdt_timeout   (wdt_timeout),
    .wdt_en        (wdt_en),
    .dev_reset_req (dev_reset_req),
    .irq_pend      (irq_pend),
    .in_awake      (in_awake),
    .pd_flag       (pd_flag),
    .to_flag       (to_flag),
    .wdt_clear     (wdt_clear),
    .osc_en        (osc_en),
    .asleep        (asleep),
    .resume        (resume),
    .vector_req    (vector_req),
    .reset_out     (reset_out)
);

// File: tb/slpwake_ctrl_tb_top.sv
// Self-checking bench for slpwake_ctrl. A behavioural reference model is
// compared with every output on each falling edge, and directed checks are
// made at the key cycles of each scenario.
module slpwake_ctrl_tb_top;
    localparam int NS  = 3;
    localparam int OST = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_exec = 1'b0, wdt_timeout = 1'b0, wdt_en = 1'b0, dev_reset_req = 1'b0;
    logic [NS-1:0] int_flags = '0, int_ens = '0;
    logic gie = 1'b0, osc_rc_mode = 1'b0;
    logic pd_flag, to_flag, wdt_clear, osc_en, asleep, ost_busy, resume, vector_req, reset_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 1'b0;

    always #5 clk = ~clk;

    slpwake_ctrl #(.N_SRC(NS), .OST_CYCLES(OST)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .wdt_timeout(wdt_timeout),
        .wdt_en(wdt_en), .dev_reset_req(dev_reset_req), .int_flags(int_flags),
        .int_ens(int_ens), .gie(gie), .osc_rc_mode(osc_rc_mode), .pd_flag(pd_flag),
        .to_flag(to_flag), .wdt_clear(wdt_clear), .osc_en(osc_en), .asleep(asleep),
        .ost_busy(ost_busy), .resume(resume), .vector_req(vector_req), .reset_out(reset_out)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model. Phases: 0 awake, 1 asleep, 2 start-up wait,
    // 3 resume, 4 next instruction, 5 dummy, 6 vector request.
    int m_phase = 0, m_left = 0;
    bit m_pd = 1, m_to = 1, m_wclr = 0, m_rst = 0, m_vec = 0;

    always @(posedge clk) begin
        bit pend;
        bit wd;
        pend = |(int_flags & int_ens);
        wd   = wdt_timeout && wdt_en;
        started = 1'b1;
        if (!rst_n) begin
            m_phase = 0; m_pd = 1; m_to = 1; m_wclr = 0; m_rst = 0; m_vec = 0;
        end else begin
            m_wclr = 0;
            m_rst  = 0;
            if (dev_reset_req) begin
                m_rst = 1;
                m_phase = 0;
            end else if (m_phase == 0) begin
                if (wd) begin
                    m_to = 0; m_rst = 1;
                end else if (sleep_exec && !pend) begin
                    m_pd = 0; m_to = 1; m_wclr = 1; m_phase = 1;
                end
            end else if (m_phase == 1) begin
                if (wd || pend) begin
                    if (wd) m_to = 0;
                    m_vec = !wd && gie;
                    if (osc_rc_mode) m_phase = 3;
                    else begin m_phase = 2; m_left = OST; end
                end
            end else if (m_phase == 2) begin
                m_left--;
                if (m_left == 0) m_phase = 3;
            end else if (m_phase == 3) begin
                m_phase = m_vec ? 4 : 0;
            end else if (m_phase == 6) begin
                m_phase = 0;
            end else begin
                m_phase++;
            end
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        cycles++;
        if (started) begin
            chk("R2 pd_flag", pd_flag, m_pd);
            chk("R6 to_flag", to_flag, m_to);
            chk("R2 wdt_clear", wdt_clear, m_wclr);
            chk("R7 osc_en", osc_en, m_phase != 1);
            chk("R4 asleep", asleep, m_phase == 1);
            chk("R9 ost_busy", ost_busy, m_phase == 2);
            chk("R10 resume", resume, m_phase == 3);
            chk("R11 vector_req", vector_req, m_phase == 6);
            chk("R7 reset_out", reset_out, m_rst);
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_sleep();
        sleep_exec = 1'b1;
        cyc();
        sleep_exec = 1'b0;
    endtask

    initial begin
        int n;
        int pd_before;
        cyc(3);
        // R1: reset state
        chk("R1 pd_flag", pd_flag, 1); chk("R1 to_flag", to_flag, 1);
        chk("R1 osc_en", osc_en, 1);   chk("R1 asleep", asleep, 0);
        chk("R1 resume", resume, 0);   chk("R1 vector_req", vector_req, 0);
        rst_n = 1'b1;
        cyc();
        chk("R1 wdt_clear", wdt_clear, 0); chk("R1 reset_out", reset_out, 0);

        // R8: watchdog timeout while awake
        wdt_timeout = 1'b1; wdt_en = 1'b1;
        cyc();
        wdt_timeout = 1'b0;
        chk("R8 to_flag", to_flag, 0); chk("R8 reset_out", reset_out, 1);
        chk("R8 pd_flag", pd_flag, 1); chk("R8 asleep", asleep, 0);
        cyc();

        // R2: clean sleep entry
        do_sleep();
        chk("R2 asleep", asleep, 1); chk("R2 pd_flag", pd_flag, 0);
        chk("R2 to_flag", to_flag, 1); chk("R2 wdt_clear", wdt_clear, 1);
        chk("R2 osc_en", osc_en, 0);
        cyc();
        chk("R2 wdt_clear pulse", wdt_clear, 0);

        // R5/R9/R10: interrupt wake with gie=0 in crystal mode
        int_flags = 3'b010; int_ens = 3'b010; gie = 1'b0;
        cyc();
        int_flags = '0;
        chk("R5 asleep", asleep, 0); chk("R5 osc_en", osc_en, 1);
        n = 0;
        while (ost_busy && n < 100) begin n++; cyc(); end
        chk("R9 start-up length", n, OST);
        chk("R10 resume", resume, 1);
        cyc();
        chk("R10 resume pulse", resume, 0);
        cyc(3);
        chk("R10 no vector", vector_req, 0);

        // R3: sleep with an enabled flag already pending
        pd_before = int'(pd_flag);
        int_flags = 3'b001; int_ens = 3'b001;
        do_sleep();
        chk("R3 asleep", asleep, 0); chk("R3 wdt_clear", wdt_clear, 0);
        chk("R3 pd_flag", pd_flag, pd_before);
        int_flags = '0;
        cyc();

        // R4: disabled flag neither blocks nor ends sleep
        int_flags = 3'b100; int_ens = 3'b011;
        do_sleep();
        chk("R4 asleep", asleep, 1);
        cyc(3);
        chk("R4 still asleep", asleep, 1);

        // R6: watchdog wake gated by wdt_en, RC mode (R9)
        wdt_timeout = 1'b1; wdt_en = 1'b0;
        cyc();
        chk("R6 gated", asleep, 1);
        wdt_en = 1'b1; osc_rc_mode = 1'b1; gie = 1'b1;
        cyc();
        wdt_timeout = 1'b0; int_flags = '0;
        chk("R6 woke", asleep, 0); chk("R6 to_flag", to_flag, 0);
        chk("R9 rc resume", resume, 1);
        cyc();
        chk("R10 resume pulse", resume, 0);
        cyc(3);
        chk("R6 no vector", vector_req, 0);

        // R5/R11: flag rises the cycle after the sleep strobe, gie=1
        int_ens = 3'b001;
        do_sleep();
        int_flags = 3'b001;
        chk("R5 sleep completed", asleep, 1); chk("R5 pd_flag", pd_flag, 0);
        chk("R5 wdt_clear", wdt_clear, 1);
        cyc();
        int_flags = '0;
        chk("R5 woke", asleep, 0); chk("R11 resume", resume, 1);
        cyc();
        chk("R11 next instr", vector_req, 0);
        cyc();
        chk("R11 dummy", vector_req, 0);
        cyc();
        chk("R11 vector", vector_req, 1);
        cyc();
        chk("R11 vector pulse", vector_req, 0);

        // R7/R12: reset beats watchdog and interrupt while asleep
        do_sleep();
        dev_reset_req = 1'b1; wdt_timeout = 1'b1; int_flags = 3'b001;
        cyc();
        dev_reset_req = 1'b0; wdt_timeout = 1'b0; int_flags = '0;
        chk("R12 reset_out", reset_out, 1); chk("R12 to_flag kept", to_flag, 1);
        chk("R7 osc_en", osc_en, 1); chk("R12 no resume", resume, 0);
        cyc();
        chk("R7 reset pulse", reset_out, 0);
        cyc(3);
        chk("R12 no vector after reset", vector_req, 0);

        // R12: watchdog beats interrupt while asleep
        do_sleep();
        wdt_timeout = 1'b1; int_flags = 3'b001;
        cyc();
        wdt_timeout = 1'b0; int_flags = '0;
        chk("R12 to_flag", to_flag, 0); chk("R12 resume", resume, 1);
        cyc(3);
        chk("R12 no vector", vector_req, 0);
        cyc(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule